// File: doc/BRIEF.md
# PHY Management Register Bank

This block models the management register space of a 10/100 Ethernet PHY. The space has thirty-two 16-bit locations. A simple port carries a 5-bit register number, a write strobe and write data. Read data comes back combinationally from the register number.

Most locations are plain storage with fixed reset values. Three locations are computed live from a registered copy of the link input and from the stored advertisement word (location 4):

- **Basic status** (location 1).
- **Partner ability** (location 5).
- **Diagnostic** (location 18).

Because of this, a driver always finds auto-negotiation finished. The result it sees is whatever best mode it advertised itself. A duplex flag is also exported, so a MAC can compare it with its own duplex setting.

The read path uses a decoded source selector, `rd_kind_t`, with four named values:

- `RK_STORED`: any location other than 1, 5 and 18.
- `RK_STATUS`: location 1.
- `RK_PARTNER`: location 5.
- `RK_DIAG`: location 18.

The only sequential state is the storage array and the link flag. The link flag has two states, up and down. Reset puts it in up. On every clock it moves to the sampled value of `link_up_i`.

Top module: `phy_mgmt_regs`

## Requirements
- R1: While reset is held and after it, location 0 reads 0x3100, location 2 reads 0x0300, location 3 reads 0xE400, location 4 reads 0x01E1, and every other plain location reads 0x0000.
- R2: The link flag resets to up, whatever `link_up_i` is. It then takes the value of `link_up_i` at each rising clock edge.
- R3: With the link flag up, location 1 reads 0x782C, that is bits 14, 13, 12, 11, 5, 3 and 2 set. With the link flag down, it reads 0x0000.
- R4: Location 5 reads bit 14 set, bits 8:5 equal to location 4 bits 8:5, bit 0 set, and all other bits zero, independent of the link.
- R5: With the link flag up, location 18 bit 10 is set exactly when location 4 bit 7 or bit 8 is set.
- R6: With the link flag up, location 18 bit 11 is set exactly when location 4 bit 8 or bit 6 is set. Location 18 has no other bits set. With the link flag down, it reads 0x0000.
- R7: `duplex_o` always equals bit 11 of what location 18 reads.
- R8: A write stores `wr_data_i` into the selected location at the rising edge where `wr_en_i` is high. The read of that location in the following cycle returns it.
- R9: Writes to locations 1, 5 and 18 do not change what those locations read.
- R10: Read data follows `reg_sel_i` within the same cycle, without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| link_up_i | input | 1 | Link state from the line side, 1 = up |
| reg_sel_i | input | 5 | Register number for read and write |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data of the selected location |
| duplex_o | output | 1 | Full-duplex result of the model |

## Verification
Read data is due in the same cycle as a new register number. The bench changes `reg_sel_i` on a falling edge and samples one nanosecond later, with no clock edge in between. A write, and a change of `link_up_i`, is due one rising edge later, because each passes through exactly one register. The bench therefore drives these on a falling edge and samples on the following falling edge, after a single rising edge. Computed locations that depend on the advertisement word follow a write to location 4 with that same one-edge latency, so they are checked on the falling edge after the write.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int REG_CNT = 32;
    localparam int DATA_W  = 16;
    localparam int SEL_W   = $clog2(REG_CNT);

    localparam logic [SEL_W-1:0] LOC_CTRL    = SEL_W'(0);
    localparam logic [SEL_W-1:0] LOC_STATUS  = SEL_W'(1);
    localparam logic [SEL_W-1:0] LOC_ID_HI   = SEL_W'(2);
    localparam logic [SEL_W-1:0] LOC_ID_LO   = SEL_W'(3);
    localparam logic [SEL_W-1:0] LOC_ADV     = SEL_W'(4);
    localparam logic [SEL_W-1:0] LOC_PARTNER = SEL_W'(5);
    localparam logic [SEL_W-1:0] LOC_DIAG    = SEL_W'(18);

    // advertisement bit positions
    localparam int ADV_10H  = 5;
    localparam int ADV_10F  = 6;
    localparam int ADV_100H = 7;
    localparam int ADV_100F = 8;

    localparam logic [DATA_W-1:0] STATUS_UP   = 16'h782C;
    localparam logic [DATA_W-1:0] PARTNER_FIX = 16'h4001;
    localparam int DIAG_SPD_BIT = 10;
    localparam int DIAG_DPX_BIT = 11;

    typedef enum logic [1:0] {
        RK_STORED,
        RK_STATUS,
        RK_PARTNER,
        RK_DIAG
    } rd_kind_t;

    function automatic logic [DATA_W-1:0] reset_value(input int idx);
        unique case (idx)
            0:       return 16'h3100;
            2:       return 16'h0300;
            3:       return 16'hE400;
            4:       return 16'h01E1;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/phy_reg_store.sv
module phy_reg_store
    import phy_mgmt_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en_i,
    input  logic [SEL_W-1:0]               wr_sel_i,
    input  logic [DATA_W-1:0]              wr_data_i,
    output logic [REG_CNT-1:0][DATA_W-1:0] regs_o
);

    for (genvar g = 0; g < REG_CNT; g++) begin : g_loc
        localparam logic [DATA_W-1:0] RST_VAL = reset_value(g);
        logic hit;

        assign hit = wr_en_i && (wr_sel_i == SEL_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_o[g] <= RST_VAL;
            end else if (hit) begin
                regs_o[g] <= wr_data_i;
            end
        end
    end

endmodule

// File: rtl/phy_live_regs.sv
module phy_live_regs
    import phy_mgmt_pkg::*;
(
    input  logic              link_i,
    input  logic [8:5]        adv_modes_i,
    output logic [DATA_W-1:0] status_o,
    output logic [DATA_W-1:0] partner_o,
    output logic [DATA_W-1:0] diag_o
);

    logic fast;
    logic full;

    assign fast = adv_modes_i[ADV_100H] | adv_modes_i[ADV_100F];
    assign full = adv_modes_i[ADV_100F] | adv_modes_i[ADV_10F];

    always_comb begin
        status_o  = link_i ? STATUS_UP : '0;

        partner_o = PARTNER_FIX;
        partner_o[ADV_100F:ADV_10H] = adv_modes_i;

        diag_o = '0;
        if (link_i) begin
            diag_o[DIAG_SPD_BIT] = fast;
            diag_o[DIAG_DPX_BIT] = full;
        end
    end

endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        link_up_i,
    input  logic [4:0]  reg_sel_i,
    input  logic        wr_en_i,
    input  logic [15:0] wr_data_i,
    output logic [15:0] rd_data_o,
    output logic        duplex_o
);

    logic                           link_q;
    logic [REG_CNT-1:0][DATA_W-1:0] regs;
    logic [DATA_W-1:0]              status_w;
    logic [DATA_W-1:0]              partner_w;
    logic [DATA_W-1:0]              diag_w;
    rd_kind_t                       kind;

    // link flag: up out of reset, then follows the input
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            link_q <= 1'b1;
        end else begin
            link_q <= link_up_i;
        end
    end

    phy_reg_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (reg_sel_i),
        .wr_data_i (wr_data_i),
        .regs_o    (regs)
    );

    phy_live_regs u_live (
        .link_i      (link_q),
        .adv_modes_i (regs[LOC_ADV][ADV_100F:ADV_10H]),
        .status_o    (status_w),
        .partner_o   (partner_w),
        .diag_o      (diag_w)
    );

    always_comb begin
        unique case (reg_sel_i)
            LOC_STATUS:  kind = RK_STATUS;
            LOC_PARTNER: kind = RK_PARTNER;
            LOC_DIAG:    kind = RK_DIAG;
            default:     kind = RK_STORED;
        endcase
    end

    always_comb begin
        unique case (kind)
            RK_STATUS:  rd_data_o = status_w;
            RK_PARTNER: rd_data_o = partner_w;
            RK_DIAG:    rd_data_o = diag_w;
            default:    rd_data_o = regs[reg_sel_i];
        endcase
    end

    assign duplex_o = diag_w[DIAG_DPX_BIT];

endmodule

// File: rtl/phy_mgmt_regs_chk.sv
module phy_mgmt_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        link_up_i,
    input logic [4:0]  reg_sel_i,
    input logic        wr_en_i,
    input logic [15:0] wr_data_i,
    input logic [15:0] rd_data_o,
    input logic        duplex_o
);

    logic plain_sel;
    assign plain_sel = (reg_sel_i != 5'd1) && (reg_sel_i != 5'd5) && (reg_sel_i != 5'd18);

    AST_STATUS_UP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(link_up_i) && reg_sel_i == 5'd1) |-> rd_data_o == 16'h782C); // R3

    AST_STATUS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(link_up_i) && reg_sel_i == 5'd1) |-> rd_data_o == 16'h0000); // R3

    AST_PARTNER_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel_i == 5'd5) |-> (rd_data_o[14] && rd_data_o[0] && (rd_data_o & 16'hBE1E) == 16'h0)); // R4

    AST_DIAG_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel_i == 5'd18) |-> ((rd_data_o & 16'hF3FF) == 16'h0)); // R6

    AST_DUPLEX_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel_i == 5'd18) |-> (rd_data_o[11] == duplex_o)); // R7

    AST_DUPLEX_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(link_up_i)) |-> !duplex_o); // R6

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en_i) && plain_sel && reg_sel_i == $past(reg_sel_i))
        |-> rd_data_o == $past(wr_data_i)); // R8

endmodule

bind phy_mgmt_regs phy_mgmt_regs_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_up_i (link_up_i),
    .reg_sel_i (reg_sel_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .duplex_o  (duplex_o)
);

// File: tb/test_phy_mgmt_regs.sv
module test_phy_mgmt_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_up_i = 1'b0;
    logic [4:0]  reg_sel_i = '0;
    logic        wr_en_i = 1'b0;
    logic [15:0] wr_data_i = '0;
    logic [15:0] rd_data_o;
    logic        duplex_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    phy_mgmt_regs i_phy_mgmt_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_up_i (link_up_i),
        .reg_sel_i (reg_sel_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .rd_data_o (rd_data_o),
        .duplex_o  (duplex_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // combinational read: drive on falling edge, sample 1 ns later
    task automatic rd(input logic [4:0] sel, output logic [15:0] val);
        @(negedge clk);
        reg_sel_i = sel;
        #1;
        val = rd_data_o;
    endtask

    task automatic wr(input logic [4:0] sel, input logic [15:0] data);
        @(negedge clk);
        reg_sel_i = sel;
        wr_data_i = data;
        wr_en_i   = 1'b1;
        @(negedge clk);
        wr_en_i   = 1'b0;
    endtask

    task automatic set_link(input logic up);
        @(negedge clk);
        link_up_i = up;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(5'd0, v);  chk("R1 loc0", v, 16'h3100);
        rd(5'd2, v);  chk("R1 loc2", v, 16'h0300);
        rd(5'd3, v);  chk("R1 loc3", v, 16'hE400);
        rd(5'd4, v);  chk("R1 loc4", v, 16'h01E1);
        rd(5'd7, v);  chk("R1 loc7", v, 16'h0000);
        rd(5'd31, v); chk("R1 loc31", v, 16'h0000);
        rd(5'd1, v);  chk("R2 link up in reset", v, 16'h782C);
        chk("R7 duplex in reset", {15'b0, duplex_o}, 16'h0001);
    endtask

    task automatic t_link;
        logic [15:0] v;
        @(negedge clk);
        rst_n = 1'b1;            // link_up_i still 0
        @(negedge clk);
        rd(5'd1, v);  chk("R3 status down", v, 16'h0000);
        rd(5'd18, v); chk("R6 diag down", v, 16'h0000);
        chk("R7 duplex down", {15'b0, duplex_o}, 16'h0000);
        set_link(1'b1);
        rd(5'd1, v);  chk("R3 status up", v, 16'h782C);
        rd(5'd18, v); chk("R6 diag default", v, 16'h0C00);
        chk("R7 duplex up", {15'b0, duplex_o}, 16'h0001);
    endtask

    task automatic t_adv(input logic [15:0] adv, input logic [15:0] exp_p,
                         input logic [15:0] exp_d);
        logic [15:0] v;
        wr(5'd4, adv);
        rd(5'd5, v);  chk("R4 partner", v, exp_p);
        rd(5'd18, v); chk("R5 R6 diag", v, exp_d);
        chk("R7 duplex", {15'b0, duplex_o}, {15'b0, exp_d[11]});
    endtask

    task automatic t_write;
        logic [15:0] v;
        wr(5'd9, 16'hA5C3);
        rd(5'd9, v);  chk("R8 loc9", v, 16'hA5C3);
        wr(5'd0, 16'h1234);
        rd(5'd0, v);  chk("R8 loc0", v, 16'h1234);
        rd(5'd9, v);  chk("R8 loc9 kept", v, 16'hA5C3);
        wr(5'd1, 16'h0000);
        rd(5'd1, v);  chk("R9 loc1", v, 16'h782C);
        wr(5'd5, 16'hFFFF);
        rd(5'd5, v);  chk("R9 loc5", v, 16'h4101);
        wr(5'd18, 16'h0000);
        rd(5'd18, v); chk("R9 loc18", v, 16'h0C00);
    endtask

    task automatic t_comb;
        // R10: change selector and sample with no clock edge between
        @(negedge clk);
        reg_sel_i = 5'd3;
        #0.5;
        chk("R10 loc3", rd_data_o, 16'hE400);
        reg_sel_i = 5'd9;
        #0.5;
        chk("R10 loc9", rd_data_o, 16'hA5C3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_link();
        t_adv(16'h0021, 16'h4021, 16'h0000);
        t_adv(16'h0041, 16'h4041, 16'h0800);
        t_adv(16'h0081, 16'h4081, 16'h0400);
        t_adv(16'h0101, 16'h4101, 16'h0C00);
        t_adv(16'hFFFF, 16'h41E1, 16'h0C00);
        t_adv(16'h0101, 16'h4101, 16'h0C00);
        t_write();
        t_comb();
        set_link(1'b0);
        begin
            logic [15:0] v;
            rd(5'd5, v);  chk("R4 partner link down", v, 16'h4101);
            rd(5'd18, v); chk("R6 diag after drop", v, 16'h0000);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule